// File: doc/BRIEF.md
# Serial Configuration Reload Sequencer

This block lives in core logic and reloads a serially loaded configuration register without a test-access-port controller. A client presents a full parallel image and pulses a start request. The sequencer takes a copy of the image and moves it out one bit per enabled clock on a serial data line while holding shift enable high. It then leaves one quiet cycle and raises a single update strobe that commits the new contents. The block reports busy while a reload is in progress and pulses done once when the reload is finished.

Five named states drive the sequence. IDLE waits for start. Start moves IDLE to SHIFT, and the image is latched at that moment. SHIFT lasts one enabled cycle per image bit. When the last bit has gone out, SHIFT moves to GAP. GAP is one cycle with both control lines low and always moves to UPDATE. UPDATE is one strobe cycle and always moves to DONE. DONE is one cycle that pulses done and always returns to IDLE.

A clock-enable input freezes the machine. A cycle with the enable low changes no state and no bit count, and it holds every strobe low. The most significant image bit is read-only in the target register. The sequencer sends that bit exactly as it receives it.

Top module: `cfgseq_loader`

## Requirements
- R1: After reset the block is in IDLE, and shift_en, update_stb, busy and done are all low.
- R2: Each reload has exactly IMG_W (default 81) enabled cycles with shift_en high. In the k-th of these cycles ser_data carries image bit k, so bit 0 goes out first and bit IMG_W-1 goes out last. Every bit, the top bit included, goes out unaltered.
- R3: update_stb is never high in a cycle where shift_en is high.
- R4: Between the last shift cycle and the update cycle there is exactly one enabled cycle in which busy is high and both shift_en and update_stb are low.
- R5: update_stb is high for exactly one enabled cycle per reload.
- R6: done is high for exactly one cycle, the enabled cycle right after the update cycle. busy is low while done is high, and the block is then back in IDLE.
- R7: The image is captured in the cycle that start is accepted. Later changes on the image input do not affect the bits that are sent.
- R8: A start request that arrives while a reload is in progress is ignored. It neither changes the bits being sent nor starts a second reload.
- R9: In a cycle with clk_en low, shift_en, update_stb and done are low, and the state and bit count do not advance. A paused reload still delivers the same bit sequence.
- R10: busy is high from the cycle after start is accepted through the update cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Advances the sequence when high. A low value pauses it |
| start | input | 1 | Reload request, sampled in IDLE |
| image | input | IMG_W | Parallel configuration image |
| ser_data | output | 1 | Serial configuration data, bit 0 first |
| shift_en | output | 1 | Shift enable for the target register |
| update_stb | output | 1 | Commit strobe for the target register |
| busy | output | 1 | A reload is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that clk_en is stable for the whole cycle around each rising edge. They also assume that start and image change only away from the edge. The bench meets both conditions by driving every input on the falling edge and sampling one time unit later. The assertions place no restriction on when start arrives, because the design must ignore it outside IDLE. The bench therefore injects start on purpose during SHIFT. It also drives periodic clk_en drop-outs, which must freeze the sequence while keeping every strobe quiet.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SHIFT  = 3'd1,
        ST_GAP    = 3'd2,
        ST_UPDATE = 3'd3,
        ST_DONE   = 3'd4
    } seq_state_t;

endpackage

// File: rtl/cfgseq_bitcnt.sv
module cfgseq_bitcnt #(
    parameter int IMG_W = 81,
    localparam int CW   = $clog2(IMG_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          at_last
);

    localparam logic [CW-1:0] LAST = CW'(IMG_W - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_last = (cnt == LAST);

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/cfgseq_shreg.sv
module cfgseq_shreg #(
    parameter int IMG_W = 81
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [IMG_W-1:0] par_in,
    output logic             ser_out
);

    logic [IMG_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load) begin
            hold_q <= par_in;
        end else if (shift) begin
            hold_q <= {1'b0, hold_q[IMG_W-1:1]};
        end
    end

    assign ser_out = hold_q[0];

endmodule

// File: rtl/cfgseq_loader.sv
module cfgseq_loader
    import cfgseq_pkg::*;
#(
    parameter int IMG_W = 81,
    localparam int CW   = $clog2(IMG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             start,
    input  logic [IMG_W-1:0] image,
    output logic             ser_data,
    output logic             shift_en,
    output logic             update_stb,
    output logic             busy,
    output logic             done
);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] bit_cnt;
    logic          cnt_last;
    logic          accept;
    logic          advance_bit;

    assign accept      = clk_en && (state_q == ST_IDLE) && start;
    assign advance_bit = clk_en && (state_q == ST_SHIFT);

    cfgseq_bitcnt #(.IMG_W(IMG_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .inc     (advance_bit),
        .cnt     (bit_cnt),
        .at_last (cnt_last)
    );

    cfgseq_shreg #(.IMG_W(IMG_W)) u_sreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .shift   (advance_bit),
        .par_in  (image),
        .ser_out (ser_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (clk_en) begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SHIFT;
            ST_SHIFT:  if (cnt_last) state_d = ST_GAP;
            ST_GAP:    state_d = ST_UPDATE;
            ST_UPDATE: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        shift_en   = 1'b0;
        update_stb = 1'b0;
        busy       = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SHIFT:  begin busy = 1'b1; shift_en = clk_en; end
            ST_GAP:    busy = 1'b1;
            ST_UPDATE: begin busy = 1'b1; update_stb = clk_en; end
            ST_DONE:   done = clk_en;
            default:   ;
        endcase
    end

    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_en && update_stb));

    // R2
    full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && state_d == ST_GAP && clk_en) |-> (bit_cnt == CW'(IMG_W - 1)));

    // R5
    single_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (update_stb) |=> !update_stb);

    // R6
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(state_q) && $stable(bit_cnt)));

    // R9
    pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> !(shift_en || update_stb || done));

endmodule

// File: tb/tb_cfgseq_loader.sv
module tb_cfgseq_loader;

    localparam int W = 81;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_en = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] image = '0;
    logic         ser_data, shift_en, update_stb, busy, done;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    cfgseq_loader #(.IMG_W(W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .start      (start),
        .image      (image),
        .ser_data   (ser_data),
        .shift_en   (shift_en),
        .update_stb (update_stb),
        .busy       (busy),
        .done       (done)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_load(input logic [W-1:0] img, input bit pause, input bit poke);
        logic [W-1:0] rcv = '0;
        int  nsh = 0, nupd = 0, ndone = 0, cyc = 0;
        int  last_kind = 0;
        bit  fin = 0, seq_ok = 1, strobe_ok = 1, busy_ok = 1;
        @(negedge clk);
        clk_en = 1'b1; image = img; start = 1'b1;
        @(negedge clk);
        start = 1'b0; image = ~img;
        #1;
        chk(busy === 1'b1, "R10 busy after start", busy, 1);
        while (!fin && cyc < 1000) begin
            clk_en = !(pause && (cyc % 3 == 1));
            start  = (poke && (cyc == 20 || cyc == 21));
            if (poke && cyc == 20) image = {W{1'b1}} ^ img;
            #1;
            if (shift_en && update_stb) strobe_ok = 0;
            if (!clk_en) begin
                if (shift_en || update_stb || done) strobe_ok = 0;
            end else if (shift_en) begin
                if (nsh < W) rcv[nsh] = ser_data;
                nsh++;
                if (nupd != 0) seq_ok = 0;
                last_kind = 1;
            end else if (update_stb) begin
                nupd++;
                if (last_kind != 2) seq_ok = 0;
                last_kind = 3;
            end else if (done) begin
                ndone++;
                if (last_kind != 3) seq_ok = 0;
                if (busy) busy_ok = 0;
                fin = 1;
            end else if (busy) begin
                if (last_kind == 1) last_kind = 2;
                else seq_ok = 0;
            end else begin
                busy_ok = 0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; clk_en = 1'b1;
        chk(fin, "R6 done reached", fin, 1);
        chk(nsh == W, "R2 shift count", nsh, W);
        chk(rcv === img, "R2 R7 bit order and latch", rcv, img);
        chk(rcv[W-1] === img[W-1], "R2 top bit unaltered", rcv[W-1], img[W-1]);
        chk(nupd == 1, "R5 update count", nupd, 1);
        chk(ndone == 1, "R6 done count", ndone, 1);
        chk(seq_ok, "R4 shift-gap-update-done order", seq_ok, 1);
        chk(strobe_ok, pause ? "R9 quiet when paused" : "R3 no overlap", strobe_ok, 1);
        chk(busy_ok, "R10 busy through update", busy_ok, 1);
        for (int i = 0; i < 4; i++) begin
            #1;
            chk(!shift_en && !update_stb && !busy && !done,
                poke ? "R8 no second reload" : "R6 back in idle",
                {shift_en, update_stb, busy, done}, 0);
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        logic [W-1:0] v;
        repeat (3) @(negedge clk);
        #1;
        chk({shift_en, update_stb, busy, done} == 0, "R1 reset outputs",
            {shift_en, update_stb, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk({shift_en, update_stb, busy, done} == 0, "R1 idle after reset",
            {shift_en, update_stb, busy, done}, 0);

        run_load('0, 0, 0);
        run_load({W{1'b1}}, 0, 0);
        v = '0; v[W-1] = 1'b1;
        run_load(v, 0, 0);
        run_load({1'b0, {(W-1){1'b1}}}, 0, 0);
        for (int k = 0; k < W; k += 7) begin
            v = '0; v[k] = 1'b1;
            run_load(v, 0, 0);
        end
        v = '0;
        for (int k = 0; k < W; k++) v[k] = ((k * 5 + 3) % 7) < 3;
        run_load(v, 0, 0);
        run_load(v, 1, 0);
        run_load(~v, 1, 0);
        run_load(v, 0, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule